// File: doc/BRIEF.md
# Monitor Mode and Vector Remap Controller

This block chooses the operating mode of a small processor core: user mode, monitor mode or forced monitor mode. While either monitor mode is active it steers the reset and software-interrupt vector fetches from the top address page to the page just below it, so the core starts in the monitor firmware and not in user code. It also turns off the watchdog whenever monitor operation calls for it.

Monitor mode is entered on a software-interrupt strobe or on a reset-pin release, provided that a high-voltage level is present on the IRQ or RST input. In user mode the block watches the fetch of the reset vector. If both bytes of that vector read as erased (all ones), it issues a fixed-length internal reset and comes out of that reset in forced monitor mode. Forced monitor mode then survives every later reset except power-on.

Top module: `mon_mode_ctrl`

## Requirements
- R1: After power-on reset (`rst_ni` low), `mode_o` is 0 (user), and `int_rst_o` and `cop_dis_o` are both 0.
- R2: When `rst_pin_i` goes from 0 to 1, `mode_o` becomes 1 (monitor) one cycle later if `hv_irq_i` or `hv_rst_i` is 1, and 0 (user) otherwise. This holds only when the forced flag is clear.
- R3: An `swi_i` strobe in user mode changes `mode_o` to 1 one cycle later if a high-voltage input is 1. Without a high-voltage input the strobe has no effect.
- R4: The output `vec_addr_o` is a combinational function of `addr_i`. When `mode_o` is not 0 and `addr_i` lies in $FFFC..$FFFF, the upper byte $FF is replaced by $FE and the low byte is kept. Every other address, and every address in user mode, passes through unchanged.
- R5: In monitor mode, `cop_dis_o` equals `hv_irq_i | hv_rst_i` in the same cycle. In user mode it is 0.
- R6: In user mode, a fetch (`vec_fetch_i`) of $FFFE with data $FF, followed by the next fetch of $FFFF with data $FF, drives `int_rst_o` high for exactly 16 cycles. The pulse starts in the cycle after the second fetch is sampled. While the pulse runs, pin and other reset events are ignored.
- R7: If only one of the two reset-vector bytes reads $FF, no internal reset is issued.
- R8: When the internal reset pulse ends, `mode_o` becomes 2 (forced monitor). In that mode `cop_dis_o` is 1 whatever the high-voltage inputs are.
- R9: In forced monitor mode, a pin reset or an `other_rst_i` strobe leaves `mode_o` at 2, and so does SWI. Only power-on reset returns it to 0.
- R10: When the forced flag is clear, an `other_rst_i` strobe sets `mode_o` to 1 if a high-voltage input is present and to 0 otherwise, one cycle later.
- R11: Erased-vector detection is inactive outside user mode. $FF reset-vector fetches in monitor mode issue no internal reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin_i | input | 1 | Reset pin level; a rising edge is a pin reset release |
| other_rst_i | input | 1 | Strobe for a reset release from any other non-power-on source |
| hv_irq_i | input | 1 | High voltage present on IRQ |
| hv_rst_i | input | 1 | High voltage present on RST |
| swi_i | input | 1 | Software interrupt taken strobe |
| vec_fetch_i | input | 1 | The current bus cycle is a vector fetch |
| addr_i | input | 16 | Bus address |
| data_i | input | 8 | Bus read data |
| mode_o | output | 2 | 0 user, 1 monitor, 2 forced monitor |
| vec_addr_o | output | 16 | Remapped address |
| int_rst_o | output | 1 | Internal reset request |
| cop_dis_o | output | 1 | Watchdog disable |

## Verification
The remap address and the watchdog disable are combinational: the bench changes the address or the high-voltage inputs and samples them 1 ns later, within the same cycle. Mode changes caused by pins, SWI and other resets are due one clock edge after the input is sampled, so the bench checks them 2 ns after that edge. The internal reset rises right after the edge that samples the second $FF byte. The bench checks that it is high on each of the next 16 sampling points, then checks that it is low with the mode forced. Randomized fetch pairs, SWI strobes and resets are compared against a bench model of the mode and of the forced flag.

// File: rtl/mon_pkg.sv
package mon_pkg;
  typedef enum logic [1:0] {
    MODE_USER   = 2'd0,
    MODE_MON    = 2'd1,
    MODE_FORCED = 2'd2
  } mode_e;
endpackage

// File: rtl/mon_vec_watch.sv
module mon_vec_watch #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              fetch_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              det_o
);
  localparam logic [DATA_W-1:0] ERASED  = {DATA_W{1'b1}};
  localparam logic [ADDR_W-1:0] VEC_LOW = VEC_ADDR + ADDR_W'(1);

  logic first_ff_q;
  logic data_ff;

  assign data_ff = (data_i == ERASED);

  // first byte state is replaced on every fetch, so the pair must be consecutive
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) first_ff_q <= 1'b0;
    else if (fetch_i) first_ff_q <= (addr_i == VEC_ADDR) && data_ff;
  end

  assign det_o = en_i && fetch_i && (addr_i == VEC_LOW) && data_ff && first_ff_q;
endmodule

// File: rtl/mon_rst_pulse.sv
module mon_rst_pulse #(
  parameter int PULSE_LEN = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(PULSE_LEN + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (start_i && cnt_q == '0) cnt_q <= CNT_W'(PULSE_LEN);
    else if (cnt_q != '0) cnt_q <= cnt_q - CNT_W'(1);
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/mon_vec_remap.sv
module mon_vec_remap #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  parameter logic [PAGE_W-1:0] USER_PAGE = 8'hFF,
  parameter logic [PAGE_W-1:0] MON_PAGE = 8'hFE,
  parameter logic [ADDR_W-PAGE_W-1:0] FIRST_LO = 8'hFC
) (
  input  logic              active_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int LO_W = ADDR_W - PAGE_W;

  logic hit;

  assign hit = active_i && (addr_i[ADDR_W-1 -: PAGE_W] == USER_PAGE)
            && (addr_i[LO_W-1:0] >= FIRST_LO);

  assign addr_o = hit ? {MON_PAGE, addr_i[LO_W-1:0]} : addr_i;
endmodule

// File: rtl/mon_mode_fsm.sv
module mon_mode_fsm
  import mon_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  pin_rise_i,
  input  logic  other_rst_i,
  input  logic  swi_i,
  input  logic  hv_i,
  input  logic  det_i,
  input  logic  busy_i,
  input  logic  done_i,
  output mode_e mode_o
);
  mode_e mode_q, mode_d;
  logic  forced_q;
  logic  rst_evt;

  // sticky: cleared only by power-on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) forced_q <= 1'b0;
    else if (det_i) forced_q <= 1'b1;
  end

  assign rst_evt = done_i || (!busy_i && (pin_rise_i || other_rst_i));

  always_comb begin
    mode_d = mode_q;
    if (rst_evt) begin
      if (forced_q)  mode_d = MODE_FORCED;
      else if (hv_i) mode_d = MODE_MON;
      else           mode_d = MODE_USER;
    end else if (swi_i && hv_i && !busy_i && mode_q == MODE_USER) begin
      mode_d = MODE_MON;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_USER;
    else mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/mon_mode_ctrl.sv
module mon_mode_ctrl
  import mon_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PAGE_W    = 8,
  parameter int PULSE_LEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rst_pin_i,
  input  logic              other_rst_i,
  input  logic              hv_irq_i,
  input  logic              hv_rst_i,
  input  logic              swi_i,
  input  logic              vec_fetch_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [1:0]        mode_o,
  output logic [ADDR_W-1:0] vec_addr_o,
  output logic              int_rst_o,
  output logic              cop_dis_o
);
  localparam int LO_W = ADDR_W - PAGE_W;
  localparam logic [PAGE_W-1:0] USER_PAGE = {PAGE_W{1'b1}};
  localparam logic [PAGE_W-1:0] MON_PAGE  = USER_PAGE - PAGE_W'(1);
  localparam logic [LO_W-1:0]   RST_LO    = {LO_W{1'b1}} - LO_W'(1);
  localparam logic [LO_W-1:0]   SWI_LO    = RST_LO - LO_W'(2);

  mode_e mode;
  logic  pin_q, pin_rise;
  logic  hv, det, busy, done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b1;
    else pin_q <= rst_pin_i;
  end

  assign pin_rise = rst_pin_i && !pin_q;
  assign hv = hv_irq_i || hv_rst_i;

  mon_vec_watch #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_ADDR({USER_PAGE, RST_LO})
  ) u_watch (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .en_i(mode == MODE_USER && !busy),
    .fetch_i(vec_fetch_i), .addr_i(addr_i), .data_i(data_i),
    .det_o(det)
  );

  mon_rst_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(det), .busy_o(busy), .done_o(done)
  );

  mon_mode_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_rise_i(pin_rise),
    .other_rst_i(other_rst_i), .swi_i(swi_i), .hv_i(hv), .det_i(det),
    .busy_i(busy), .done_i(done), .mode_o(mode)
  );

  mon_vec_remap #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .USER_PAGE(USER_PAGE),
    .MON_PAGE(MON_PAGE), .FIRST_LO(SWI_LO)
  ) u_remap (
    .active_i(mode != MODE_USER), .addr_i(addr_i), .addr_o(vec_addr_o)
  );

  assign mode_o    = mode;
  assign int_rst_o = busy;
  assign cop_dis_o = (mode == MODE_FORCED) || (mode == MODE_MON && hv);
endmodule

// File: rtl/mon_mode_ctrl_chk.sv
module mon_mode_ctrl_chk #(
  parameter int ADDR_W    = 16,
  parameter int PULSE_LEN = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        mode_o,
  input logic              int_rst_o,
  input logic              cop_dis_o,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] vec_addr_o
);
  localparam int RUN_W = $clog2(PULSE_LEN + 2);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (int_rst_o) run_q <= run_q + RUN_W'(1);
    else run_q <= '0;
  end

  // R6
  pulse_len_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rst_o |-> run_q < RUN_W'(PULSE_LEN));

  // R6
  pulse_len_exact_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(int_rst_o) |-> run_q == RUN_W'(PULSE_LEN));

  // R11
  pulse_user_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_rst_o |-> mode_o == 2'd0);

  // R8
  forced_cop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'd2 |-> cop_dis_o);

  // R9
  forced_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'd2 |=> mode_o == 2'd2);

  // R5
  user_cop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o == 2'd0 |-> !cop_dis_o);

  // R4
  remap_page_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o != 2'd0 && addr_i[ADDR_W-1:2] == {(ADDR_W-2){1'b1}})
      |-> vec_addr_o == {8'hFE, addr_i[7:0]});
endmodule

bind mon_mode_ctrl mon_mode_ctrl_chk #(.ADDR_W(ADDR_W), .PULSE_LEN(PULSE_LEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mode_o(mode_o), .int_rst_o(int_rst_o),
  .cop_dis_o(cop_dis_o), .addr_i(addr_i), .vec_addr_o(vec_addr_o)
);

// File: tb/sim_mon_mode_ctrl.sv
`timescale 1ns/1ps
module sim_mon_mode_ctrl;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic        rst_pin_i = 1, other_rst_i = 0, hv_irq_i = 0, hv_rst_i = 0;
  logic        swi_i = 0, vec_fetch_i = 0;
  logic [15:0] addr_i = 16'h0000;
  logic [7:0]  data_i = 8'h00;
  logic [1:0]  mode_o;
  logic [15:0] vec_addr_o;
  logic        int_rst_o, cop_dis_o;

  int errors = 0, checks = 0;
  logic [1:0] exp_mode = 0;
  logic       exp_forced = 0;
  logic       done = 0;

  always #4 clk_i = ~clk_i;

  mon_mode_ctrl u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_remap(input logic [1:0] m, input logic [15:0] a);
    if (m != 0 && a[15:8] == 8'hFF && a[7:0] >= 8'hFC) return {8'hFE, a[7:0]};
    return a;
  endfunction

  function automatic logic exp_cop(input logic [1:0] m, input logic hv);
    return (m == 2) || (m == 1 && hv);
  endfunction

  function automatic logic [1:0] exp_after_rst(input logic hv);
    if (exp_forced) return 2;
    return hv ? 2'd1 : 2'd0;
  endfunction

  task automatic tick;
    @(posedge clk_i); #2;
  endtask

  task automatic por;
    rst_ni = 0; #10; rst_ni = 1; exp_mode = 0; exp_forced = 0; tick();
  endtask

  task automatic pin_reset;
    rst_pin_i = 0; tick(); tick(); rst_pin_i = 1; tick();
  endtask

  task automatic other_reset;
    other_rst_i = 1; tick(); other_rst_i = 0;
  endtask

  task automatic swi;
    swi_i = 1; tick(); swi_i = 0;
  endtask

  // fetch pair FFFE/FFFF; returns after the edge sampling the second byte
  task automatic fetch_pair(input logic [7:0] d0, input logic [7:0] d1);
    vec_fetch_i = 1; addr_i = 16'hFFFE; data_i = d0; tick();
    addr_i = 16'hFFFF; data_i = d1; tick();
    vec_fetch_i = 0; addr_i = 16'h0000; data_i = 8'h00;
  endtask

  task automatic check_pulse(input string req);
    for (int i = 0; i < 16; i++) begin
      chk({req, " int_rst high"}, int_rst_o, 1);
      tick();
    end
    chk({req, " int_rst low after 16"}, int_rst_o, 0);
    chk("R8 mode forced after pulse", mode_o, 2);
    exp_forced = 1; exp_mode = 2;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #3; rst_ni = 0; #10; rst_ni = 1; tick();
    // R1
    chk("R1 mode", mode_o, 0); chk("R1 int_rst", int_rst_o, 0); chk("R1 cop", cop_dis_o, 0);
    // R3 without hv: no effect
    swi(); chk("R3 swi no hv", mode_o, 0);
    hv_irq_i = 1; swi(); chk("R3 swi hv", mode_o, 1);
    // R5
    #1 chk("R5 cop hv", cop_dis_o, 1);
    hv_irq_i = 0; #1 chk("R5 cop no hv", cop_dis_o, 0);
    // R4
    addr_i = 16'hFFFE; #1 chk("R4 FFFE", vec_addr_o, 16'hFEFE);
    addr_i = 16'hFFFC; #1 chk("R4 FFFC", vec_addr_o, 16'hFEFC);
    addr_i = 16'hFFFB; #1 chk("R4 FFFB", vec_addr_o, 16'hFFFB);
    addr_i = 16'h12FE; #1 chk("R4 12FE", vec_addr_o, 16'h12FE);
    // R11 in monitor mode erased vectors ignored
    fetch_pair(8'hFF, 8'hFF); chk("R11 no pulse in monitor", int_rst_o, 0);
    tick(); chk("R11 mode kept", mode_o, 1);
    // R10
    other_reset(); chk("R10 other no hv", mode_o, 0);
    addr_i = 16'hFFFE; #1 chk("R4 user no remap", vec_addr_o, 16'hFFFE);
    hv_rst_i = 1; other_reset(); chk("R10 other hv", mode_o, 1);
    hv_rst_i = 0; other_reset(); chk("R10 back user", mode_o, 0);
    // R2
    hv_rst_i = 1; pin_reset(); chk("R2 pin hv", mode_o, 1);
    hv_rst_i = 0; pin_reset(); chk("R2 pin no hv", mode_o, 0);
    // R7
    fetch_pair(8'hFF, 8'h00); chk("R7 first only", int_rst_o, 0);
    fetch_pair(8'h7F, 8'hFF); chk("R7 second only", int_rst_o, 0);
    // R6
    fetch_pair(8'hFF, 8'hFF); check_pulse("R6");
    #1 chk("R8 cop forced no hv", cop_dis_o, 1);
    // R9
    pin_reset(); chk("R9 pin keeps forced", mode_o, 2);
    other_reset(); chk("R9 other keeps forced", mode_o, 2);
    hv_irq_i = 1; swi(); chk("R9 swi keeps forced", mode_o, 2); hv_irq_i = 0;
    por(); chk("R1 por clears forced", mode_o, 0); chk("R1 cop after por", cop_dis_o, 0);

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [7:0] d0, d1;
      logic [15:0] a;
      if (it % 60 == 59) por();
      hv_irq_i = $urandom % 2; hv_rst_i = ($urandom % 4) == 0;
      op = $urandom % 4;
      case (op)
        0: begin
          swi();
          if (exp_mode == 0 && (hv_irq_i | hv_rst_i)) exp_mode = 1;
          chk("R3 random swi", mode_o, exp_mode);
        end
        1: begin
          other_reset(); exp_mode = exp_after_rst(hv_irq_i | hv_rst_i);
          chk("R10 random other", mode_o, exp_mode);
        end
        2: begin
          d0 = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom % 255);
          d1 = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom % 255);
          fetch_pair(d0, d1);
          if (exp_mode == 0 && d0 == 8'hFF && d1 == 8'hFF) check_pulse("R6 random");
          else chk("R7 random no pulse", int_rst_o, 0);
        end
        default: begin
          pin_reset(); exp_mode = exp_after_rst(hv_irq_i | hv_rst_i);
          chk("R2 random pin", mode_o, exp_mode);
        end
      endcase
      a = ($urandom % 2) ? {8'hFF, 8'($urandom)} : 16'($urandom);
      addr_i = a; #1;
      chk("R4 random remap", vec_addr_o, exp_remap(exp_mode, a));
      chk("R5 random cop", cop_dis_o, exp_cop(exp_mode, hv_irq_i | hv_rst_i));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule